// File: doc/BRIEF.md
# Multiplexer-Based Logic Cell

This block models a configurable logic cell of the kind found in row-based, one-time-programmable arrays. Every function comes from 2:1 and 4:1 multiplexers whose selects are driven by small gates instead of plain select pins. This lets one cell produce many three- and four-input functions. Three variants share one set of pins: a cascade of three 2:1 multiplexers, a combinational 4:1 cell, and a sequential cell that registers the 4:1 result in a flip-flop with an asynchronous clear.

The block is `WIDTH` lanes wide. Each lane is an independent cell, and all lanes share the clock, the clear and the variant selection. A 2-bit `mode` input picks the variant that drives `y`. The registered output `q` loads only while the sequential variant is selected, and it keeps its value at all other times.

Top module: `mux_logic_cell`

## Requirements
- R1: With `mode` = 2'b00 (three-multiplexer variant), each lane computes `first = g0 ? in1 : in0`, `second = g1 ? in3 : in2`, and `y = (g2 | g3) ? second : first`.
- R2: With `mode` = 2'b01 (combinational 4:1 variant), each lane drives `y` with data input number k, where k = 2*(g0 AND g1) + (g2 OR g3). k = 0 selects in0 and k = 3 selects in3.
- R3: With `mode` = 2'b10 (sequential variant), `y` carries the same 4:1 result that R2 defines.
- R4: With `mode` = 2'b11, `y` is all zeros.
- R5: While `mode` = 2'b10 and `clr` is low, each rising edge of `clk` loads the 4:1 result of R2 into `q`.
- R6: While `mode` is not 2'b10, `q` keeps its last value across clock edges.
- R7: `clr` (active high) forces `q` to zero at once, with no clock edge needed, and holds it at zero while `clr` stays high. After reset, `q` reads zero.
- R8: The three-multiplexer variant produces F = (A AND B) OR (NOT B AND C) OR D with in0 = C, in1 = 0, in2 = A, in3 = 1, g0 = 0, g1 = D, g2 = B, g3 = D.
- R9: Lanes are independent. Bit i of `y` and `q` depends only on bit i of the data and select inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the sequential variant, rising edge |
| clr | input | 1 | Asynchronous clear of `q`, active high |
| mode | input | 2 | Variant select: 00 three-mux, 01 4:1, 10 sequential, 11 off |
| in0 | input | WIDTH | Data input 0 per lane |
| in1 | input | WIDTH | Data input 1 per lane |
| in2 | input | WIDTH | Data input 2 per lane |
| in3 | input | WIDTH | Data input 3 per lane |
| g0 | input | WIDTH | Select gate pin 0 per lane |
| g1 | input | WIDTH | Select gate pin 1 per lane |
| g2 | input | WIDTH | Select gate pin 2 per lane |
| g3 | input | WIDTH | Select gate pin 3 per lane |
| y | output | WIDTH | Combinational output of the selected variant |
| q | output | WIDTH | Registered output of the sequential variant |

## Verification
The assertions assume that `mode` and the data and select pins change only away from the rising clock edge. They also assume that `clr` is either sampled high at an edge or changes mid-cycle with no edge between its rise and fall. The bench changes all inputs on the falling edge, or a few nanoseconds after it, and holds `clr` across at least one rising edge in every pulse. Within those limits, the capture check can compare `q` with the `y` value seen one edge earlier.

// File: rtl/mux_cell_pkg.sv
package mux_cell_pkg;
  typedef enum logic [1:0] {
    MODE_TRIPLE = 2'b00,
    MODE_QUAD   = 2'b01,
    MODE_SEQ    = 2'b10,
    MODE_OFF    = 2'b11
  } cellMode_e;

  typedef struct packed {
    logic pickTriple;
    logic pickQuad;
    logic loadReg;
  } cellStrobe_t;
endpackage

// File: rtl/mux_cell_ctrl.sv
module mux_cell_ctrl
  import mux_cell_pkg::*;
(
  input  logic [1:0]  mode,
  output cellStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    case (cellMode_e'(mode))
      MODE_TRIPLE: strobe.pickTriple = 1'b1;
      MODE_QUAD:   strobe.pickQuad   = 1'b1;
      MODE_SEQ: begin
        strobe.pickQuad = 1'b1;
        strobe.loadReg  = 1'b1;
      end
      default:     strobe = '0;
    endcase
  end
endmodule

// File: rtl/mux_cell_dp.sv
module mux_cell_dp
  import mux_cell_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  cellStrobe_t      strobe,
  input  logic [WIDTH-1:0] in0,
  input  logic [WIDTH-1:0] in1,
  input  logic [WIDTH-1:0] in2,
  input  logic [WIDTH-1:0] in3,
  input  logic [WIDTH-1:0] g0,
  input  logic [WIDTH-1:0] g1,
  input  logic [WIDTH-1:0] g2,
  input  logic [WIDTH-1:0] g3,
  output logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] q
);
  localparam int QUAD_SEL_W = 2;

  logic [WIDTH-1:0] tripleOut;
  logic [WIDTH-1:0] quadOut;
  logic [WIDTH-1:0] qReg;

  for (genvar lane = 0; lane < WIDTH; lane++) begin : g_lane
    logic firstOut;
    logic secondOut;
    logic outerSel;
    logic [3:0] quadData;
    logic [QUAD_SEL_W-1:0] quadIdx;

    // three-multiplexer cascade
    assign firstOut  = g0[lane] ? in1[lane] : in0[lane];
    assign secondOut = g1[lane] ? in3[lane] : in2[lane];
    assign outerSel  = g2[lane] | g3[lane];
    assign tripleOut[lane] = outerSel ? secondOut : firstOut;

    // gated 4:1 multiplexer
    assign quadData = {in3[lane], in2[lane], in1[lane], in0[lane]};
    assign quadIdx  = {g0[lane] & g1[lane], g2[lane] | g3[lane]};
    assign quadOut[lane] = quadData[quadIdx];

    always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
        qReg[lane] <= 1'b0;
      end else if (strobe.loadReg) begin
        qReg[lane] <= quadOut[lane];
      end
    end
  end

  always_comb begin
    if (strobe.pickTriple) begin
      y = tripleOut;
    end else if (strobe.pickQuad) begin
      y = quadOut;
    end else begin
      y = '0;
    end
  end

  assign q = qReg;
endmodule

// File: rtl/mux_logic_cell.sv
module mux_logic_cell
  import mux_cell_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] in0,
  input  logic [WIDTH-1:0] in1,
  input  logic [WIDTH-1:0] in2,
  input  logic [WIDTH-1:0] in3,
  input  logic [WIDTH-1:0] g0,
  input  logic [WIDTH-1:0] g1,
  input  logic [WIDTH-1:0] g2,
  input  logic [WIDTH-1:0] g3,
  output logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] q
);
  cellStrobe_t strobe;

  mux_cell_ctrl u_ctrl (
    .mode   (mode),
    .strobe (strobe)
  );

  mux_cell_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .clr    (clr),
    .strobe (strobe),
    .in0    (in0),
    .in1    (in1),
    .in2    (in2),
    .in3    (in3),
    .g0     (g0),
    .g1     (g1),
    .g2     (g2),
    .g3     (g3),
    .y      (y),
    .q      (q)
  );
endmodule

// File: rtl/mux_cell_chk.sv
module mux_cell_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] y,
  input logic [WIDTH-1:0] q
);
  AST_CLR_ZERO: assert property (@(posedge clk) clr |-> q == '0); // R7

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b11) |-> y == '0); // R4

  AST_SEQ_LOAD: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b10) |=> q == $past(y)); // R5

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (clr)
    (mode != 2'b10) |=> $stable(q)); // R6
endmodule

bind mux_logic_cell mux_cell_chk #(.WIDTH(WIDTH)) u_chk (
  .clk  (clk),
  .clr  (clr),
  .mode (mode),
  .y    (y),
  .q    (q)
);

// File: tb/test_mux_logic_cell.sv
module test_mux_logic_cell;
  localparam int W = 2;

  logic clk = 1'b0;
  logic clr;
  logic [1:0] mode;
  logic [W-1:0] in0, in1, in2, in3, g0, g1, g2, g3;
  logic [W-1:0] y, q;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  mux_logic_cell #(.WIDTH(W)) i_mux_logic_cell (
    .clk(clk), .clr(clr), .mode(mode),
    .in0(in0), .in1(in1), .in2(in2), .in3(in3),
    .g0(g0), .g1(g1), .g2(g2), .g3(g3),
    .y(y), .q(q)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // d = {in3,in2,in1,in0}, s = {g3,g2,g1,g0}
  function automatic logic triBit(input logic [3:0] d, input logic [3:0] s);
    logic first, second;
    first  = d[{1'b0, s[0]}];
    second = d[{1'b1, s[1]}];
    return (s[2] | s[3]) ? second : first;
  endfunction

  function automatic logic quadBit(input logic [3:0] d, input logic [3:0] s);
    int k;
    k = 2 * int'(s[0] & s[1]) + int'(s[2] | s[3]);
    return d[k];
  endfunction

  // lane 0 takes v, lane 1 takes ~v (R9)
  task automatic applyVec(input logic [7:0] v);
    logic [7:0] u;
    u = ~v;
    in0 = {u[0], v[0]}; in1 = {u[1], v[1]};
    in2 = {u[2], v[2]}; in3 = {u[3], v[3]};
    g0  = {u[4], v[4]}; g1  = {u[5], v[5]};
    g2  = {u[6], v[6]}; g3  = {u[7], v[7]};
  endtask

  function automatic logic [W-1:0] expTri(input logic [7:0] v);
    logic [7:0] u;
    u = ~v;
    return {triBit(u[3:0], u[7:4]), triBit(v[3:0], v[7:4])};
  endfunction

  function automatic logic [W-1:0] expQuad(input logic [7:0] v);
    logic [7:0] u;
    u = ~v;
    return {quadBit(u[3:0], u[7:4]), quadBit(v[3:0], v[7:4])};
  endfunction

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [W-1:0] qLast;
    logic [W-1:0] pending;
    clr = 1'b1;
    mode = 2'b00;
    applyVec(8'h00);
    repeat (3) @(negedge clk);
    check("R7 reset", q, '0);
    clr = 1'b0;

    // sequential sweep: y and capture
    mode = 2'b10;
    pending = '0;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      if (v > 0) check("R5 load", q, pending);
      applyVec(8'(v));
      #1;
      check("R3 seq y", y, expQuad(8'(v)));
      pending = expQuad(8'(v));
    end
    @(negedge clk);
    check("R5 load last", q, pending);
    qLast = q;

    // three-multiplexer sweep with hold
    mode = 2'b00;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      applyVec(8'(v));
      #1;
      check("R1 triple y", y, expTri(8'(v)));
      check("R6 hold triple", q, qLast);
    end

    // 4:1 sweep with hold
    mode = 2'b01;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      applyVec(8'(v));
      #1;
      check("R2 quad y", y, expQuad(8'(v)));
      check("R6 hold quad", q, qLast);
    end

    // off mode
    mode = 2'b11;
    for (int v = 0; v < 256; v += 17) begin
      @(negedge clk);
      applyVec(8'(v));
      #1;
      check("R4 off y", y, '0);
      check("R6 hold off", q, qLast);
    end

    // function F = AB + B'C + D on lane 0, lane 1 mirrors it
    mode = 2'b00;
    for (int f = 0; f < 16; f++) begin
      logic a, b, c, d;
      logic [W-1:0] fexp;
      {d, c, b, a} = 4'(f);
      @(negedge clk);
      in0 = {2{c}}; in1 = '0; in2 = {2{a}}; in3 = '1;
      g0 = '0; g1 = {2{d}}; g2 = {2{b}}; g3 = {2{d}};
      #1;
      fexp = {2{(a & b) | (~b & c) | d}};
      check("R8 function", y, fexp);
    end

    // async clear
    mode = 2'b10;
    @(negedge clk);
    applyVec(8'h0F);
    @(negedge clk);
    check("R5 load ones", q, 2'b01);
    #2 clr = 1'b1;
    #1 check("R7 async clear", q, '0);
    @(negedge clk);
    check("R7 clear held", q, '0);
    clr = 1'b0;
    @(negedge clk);
    check("R5 load after clear", q, 2'b01);
    applyVec(8'hF0);
    @(negedge clk);
    check("R9 lanes swap", q, 2'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule